// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block serves sixteen interrupt request lines with two eight-input controller units wired as a cascade. Unit 0 is the master and talks to the processor. Unit 1 is the slave, and its pending request is fed into master pin 2. A request event names a line number and a level. The event is steered to one unit by bit 3 of the number and to one pin by bits 2..0. Each unit keeps a request latch, a mask, an in-service set, a priority rotation offset and a vector base. Each unit also has its own edge/level selection register, with a fixed set of bits that software may write.

Software reaches the block through a byte-wide register port. This port decodes six addresses: the command and mask ports of each unit, and the two edge/level registers. The processor acknowledges an interrupt with a one-cycle `inta` pulse. One cycle later the block returns an 8-bit vector built from a unit's base and its winning line. When a unit has nothing left to offer at acknowledge time, the vector uses line 7 of that unit's base.

Top module: `pic_cascade_top`

## Requirements
- R1: After synchronous reset, `cpu_int` and `vec_vld` are 0. Every mask, request, in-service, edge/level and base register reads 0.
- R2: A request event on line k reaches unit k[3] (0 master, 1 slave) on pin k[2:0]. An event whose line number is 16..31 (bit 4 set) changes no state.
- R3: On an edge-sensed pin, a 0-to-1 transition of the line latches a request. That request stays until it is acknowledged, even if the line falls. On a level-sensed pin, the request follows the line level and is not cleared by an acknowledge.
- R4: Writing an edge/level register keeps only the bits in mask 0xF8 for the master and 0xDE for the slave. A set bit makes that pin level-sensed. Address 0x10 selects the master register and 0x11 the slave register.
- R5: Address bit 7 selects the unit (0x00/0x01 master, 0x80/0x81 slave), and address bit 0 selects the port. A write to port 0 is a command. A write to port 1 sets the mask, or sets the vector base when it is the first port-1 write after an initialise command. Reading port 1 returns the mask. Reading port 0 returns the request or in-service set, as chosen by the read-select command. Any other address is ignored and reads 0.
- R6: A unit offers its highest-priority unmasked request only when that request outranks every in-service pin. Priority runs upward from pin (rotation), starting at rotation 0.
- R7: While the slave offers a request, master pin 2 latches a request on the next clock edge. `cpu_int` is the master's offer.
- R8: An `inta` pulse produces `vec_vld` for exactly one cycle on the next cycle. If the master offers pin 2, the slave is also acknowledged and the vector is the slave base plus the slave pin. Otherwise the vector is the master base plus the master pin. An acknowledged pin enters in-service.
- R9: If the master offers nothing at acknowledge, the vector is the master base plus 7. If the master offers pin 2 but the slave offers nothing, the vector is the slave base plus 7. A unit that offers nothing is left unchanged.
- R10: An access whose `acc_bytes` is not 1 has no effect on writes and returns 0 on reads.
- R11: Command byte fields are bits [7:5] operation, bit 4 initialise and bit 3 read-select. The values are as follows. 0x10 initialises the unit: it clears the mask, in-service set, rotation and read-select, and the next port-1 write sets the base from bits [7:3]. 0x0A selects the request set for read and 0x0B the in-service set. 0x20 clears the highest-priority in-service pin. 0x60|n clears in-service pin n. 0xA0 clears the highest-priority in-service pin and makes it the lowest priority. 0xC0|n makes pin n the lowest priority.
- R12: A masked pin still latches its request but is never offered. Clearing the mask bit makes the request offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_vld | input | 1 | Request line event strobe |
| line_num | input | 5 | Request line number |
| line_lvl | input | 1 | New level of the named line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| acc_bytes | input | 3 | Access size in bytes |
| rdata | output | 8 | Read data (combinational with rd_en) |
| cpu_int | output | 1 | Interrupt request to processor |
| inta | input | 1 | Interrupt acknowledge pulse |
| vec_vld | output | 1 | Vector valid, one cycle after inta |
| vec | output | 8 | Interrupt vector |

## Verification
On every cycle, the assertions check the following. The vector strobe tracks the acknowledge pulse. A pending slave offer reaches master pin 2 on the next edge. Out-of-range line events and wide writes leave state untouched. A real acknowledge adds exactly one in-service pin, a spurious one adds none, and a level-sensed pin keeps its request through its acknowledge. Only the bench scenarios can show the vector values themselves. These include the cascade and both spurious paths, the order picked under rotation and in-service blocking, the effect of each command byte, the write masks of the edge/level registers and the address decode.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIN_N  = 8;
    localparam int PIN_W  = $clog2(PIN_N);
    localparam int UNITS  = 2;
    localparam int LINE_W = PIN_W + 2;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int ACC_W  = 3;

    typedef logic [PIN_N-1:0] pin_vec_t;
    typedef logic [PIN_W-1:0] pin_idx_t;

    typedef enum logic [2:0] {
        OP_MISC    = 3'b000,
        OP_EOI     = 3'b001,
        OP_SEOI    = 3'b011,
        OP_ROT_EOI = 3'b101,
        OP_SETPRI  = 3'b110
    } op_e;

    typedef struct packed {
        logic     found;
        pin_idx_t rel;
    } prio_t;

    typedef struct packed {
        pin_vec_t                irr;
        pin_vec_t                isr;
        pin_vec_t                imr;
        pin_vec_t                last;
        pin_idx_t                rot;
        logic                    rdsel;
        logic                    wait_base;
        logic [DATA_W-1:PIN_W]   base;
    } unit_st_t;

    typedef struct packed {
        logic hit;
        logic el_sel;
        logic unit;
        logic port;
    } dec_t;

    // Smallest relative priority present in m, counting from pin rot.
    function automatic prio_t best_rel(input pin_vec_t m, input pin_idx_t rot);
        prio_t r;
        r.found = 1'b0;
        r.rel   = '0;
        for (int p = PIN_N - 1; p >= 0; p--) begin
            if (m[pin_idx_t'(pin_idx_t'(p) + rot)]) begin
                r.found = 1'b1;
                r.rel   = pin_idx_t'(p);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_prio.sv
module pic_prio
    import pic_pkg::*;
(
    input  pin_vec_t irr,
    input  pin_vec_t imr,
    input  pin_vec_t isr,
    input  pin_idx_t rot,
    output logic     req,
    output pin_idx_t line,
    output logic     svc_found,
    output pin_idx_t svc_line
);

    prio_t pend;
    prio_t serv;

    always_comb begin
        pend      = best_rel(irr & ~imr, rot);
        serv      = best_rel(isr, rot);
        req       = pend.found && (!serv.found || (pend.rel < serv.rel));
        line      = pin_idx_t'(pend.rel + rot);
        svc_found = serv.found;
        svc_line  = pin_idx_t'(serv.rel + rot);
    end

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pin_vec_t              lvl_mode,
    input  logic                  pin_vld,
    input  pin_idx_t              pin_idx,
    input  logic                  pin_lvl,
    input  pin_vec_t              ext_set,
    input  logic                  cmd_wr,
    input  logic                  mask_wr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  rd_port,
    input  logic                  ack,
    output logic [DATA_W-1:0]     rdata,
    output logic                  int_req,
    output pin_idx_t              int_line,
    output logic [DATA_W-1:PIN_W] base_o,
    output pin_vec_t              irr_o,
    output pin_vec_t              isr_o
);

    unit_st_t st_q;
    unit_st_t st_n;
    logic     svc_found;
    pin_idx_t svc_line;
    pin_idx_t cmd_pin;

    pic_prio u_prio (
        .irr       (st_q.irr),
        .imr       (st_q.imr),
        .isr       (st_q.isr),
        .rot       (st_q.rot),
        .req       (int_req),
        .line      (int_line),
        .svc_found (svc_found),
        .svc_line  (svc_line)
    );

    assign cmd_pin = wdata[PIN_W-1:0];

    always_comb begin
        st_n = st_q;
        // request lines
        if (pin_vld) begin
            if (lvl_mode[pin_idx]) begin
                st_n.irr[pin_idx] = pin_lvl;
            end else if (pin_lvl && !st_q.last[pin_idx]) begin
                st_n.irr[pin_idx] = 1'b1;
            end
            st_n.last[pin_idx] = pin_lvl;
        end
        st_n.irr = st_n.irr | ext_set;
        // acknowledge wins over a same-cycle set on the acknowledged pin
        if (ack && int_req) begin
            if (!lvl_mode[int_line]) begin
                st_n.irr[int_line] = 1'b0;
            end
            st_n.isr[int_line] = 1'b1;
        end
        // commands
        if (cmd_wr) begin
            if (wdata[4]) begin
                st_n.imr       = '0;
                st_n.isr       = '0;
                st_n.rot       = '0;
                st_n.rdsel     = 1'b0;
                st_n.wait_base = 1'b1;
            end else begin
                case (wdata[7:5])
                    OP_MISC: begin
                        if (wdata[3]) st_n.rdsel = wdata[0];
                    end
                    OP_EOI: begin
                        if (svc_found) st_n.isr[svc_line] = 1'b0;
                    end
                    OP_ROT_EOI: begin
                        if (svc_found) begin
                            st_n.isr[svc_line] = 1'b0;
                            st_n.rot = pin_idx_t'(svc_line + pin_idx_t'(1));
                        end
                    end
                    OP_SEOI: begin
                        st_n.isr[cmd_pin] = 1'b0;
                    end
                    OP_SETPRI: begin
                        st_n.rot = pin_idx_t'(cmd_pin + pin_idx_t'(1));
                    end
                    default: ;
                endcase
            end
        end
        if (mask_wr) begin
            if (st_q.wait_base) begin
                st_n.base      = wdata[DATA_W-1:PIN_W];
                st_n.wait_base = 1'b0;
            end else begin
                st_n.imr = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    always_comb begin
        if (rd_port)         rdata = st_q.imr;
        else if (st_q.rdsel) rdata = st_q.isr;
        else                 rdata = st_q.irr;
    end

    assign base_o = st_q.base;
    assign irr_o  = st_q.irr;
    assign isr_o  = st_q.isr;

    AST_ACK_ADDS_ONE_SVC: assert property (@(posedge clk) disable iff (rst)
        (ack && int_req && !cmd_wr) |=> ($countones(st_q.isr) == $countones($past(st_q.isr)) + 1)); // R8

    AST_SPUR_KEEPS_SVC: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_req && !cmd_wr) |=> $stable(st_q.isr)); // R9

    AST_LEVEL_SURVIVES_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack && int_req && lvl_mode[int_line] && !pin_vld) |=> st_q.irr[$past(int_line)]); // R3

endmodule

// File: rtl/pic_decode.sv
module pic_decode
    import pic_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EL_ADDR = 8'h10
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ACC_W-1:0]  acc_bytes,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] CTL_FREE = {1'b1, {(ADDR_W-2){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] EL_FREE  = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic ctl_hit;
    logic el_hit;

    always_comb begin
        ctl_hit    = (addr & ~CTL_FREE) == '0;
        el_hit     = (addr & ~EL_FREE) == EL_ADDR;
        dec.hit    = (acc_bytes == ACC_W'(1)) && (ctl_hit || el_hit);
        dec.el_sel = el_hit;
        dec.unit   = el_hit ? addr[0] : addr[ADDR_W-1];
        dec.port   = addr[0];
    end

endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
    import pic_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASTER_LVL_MASK = 8'hF8,
    parameter logic [DATA_W-1:0] SLAVE_LVL_MASK  = 8'hDE,
    parameter int                CASC_PIN        = 2,
    parameter int                SPUR_PIN        = 7,
    parameter logic [ADDR_W-1:0] EL_ADDR         = 8'h10
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_vld,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_lvl,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ACC_W-1:0]  acc_bytes,
    output logic [DATA_W-1:0] rdata,
    output logic              cpu_int,
    input  logic              inta,
    output logic              vec_vld,
    output logic [DATA_W-1:0] vec
);

    localparam pin_idx_t CASC = pin_idx_t'(CASC_PIN);
    localparam pin_idx_t SPUR = pin_idx_t'(SPUR_PIN);

    dec_t                  dec;
    logic [UNITS-1:0]      req_u;
    logic [UNITS-1:0]      ack_u;
    logic [UNITS-1:0]      pinv_u;
    logic [UNITS-1:0]      cmdw_u;
    logic [UNITS-1:0]      maskw_u;
    logic [UNITS-1:0]      elw_u;
    pin_idx_t              line_u  [UNITS];
    pin_vec_t              ext_u   [UNITS];
    pin_vec_t              irr_u   [UNITS];
    pin_vec_t              isr_u   [UNITS];
    pin_vec_t              elcr_q  [UNITS];
    logic [DATA_W-1:0]     rd_u    [UNITS];
    logic [DATA_W-1:PIN_W] base_u  [UNITS];
    logic                  line_ok;
    logic [DATA_W-1:0]     vec_n;

    pic_decode #(.EL_ADDR(EL_ADDR)) u_dec (
        .addr      (addr),
        .acc_bytes (acc_bytes),
        .dec       (dec)
    );

    assign line_ok = line_vld && !line_num[LINE_W-1];

    // cascade: slave offer sets master pin CASC; slave has no cascade input
    assign ext_u[0] = req_u[1] ? (pin_vec_t'(1) << CASC_PIN) : '0;
    assign ext_u[1] = '0;
    assign ack_u[0] = inta;
    assign ack_u[1] = inta && req_u[0] && (line_u[0] == CASC);

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        localparam pin_vec_t WMASK = (u == 0) ? MASTER_LVL_MASK : SLAVE_LVL_MASK;

        assign pinv_u[u]  = line_ok && (line_num[PIN_W] == 1'(u));
        assign elw_u[u]   = wr_en && dec.hit && dec.el_sel && (dec.unit == 1'(u));
        assign cmdw_u[u]  = wr_en && dec.hit && !dec.el_sel && (dec.unit == 1'(u)) && !dec.port;
        assign maskw_u[u] = wr_en && dec.hit && !dec.el_sel && (dec.unit == 1'(u)) && dec.port;

        always_ff @(posedge clk) begin
            if (rst) begin
                elcr_q[u] <= '0;
            end else if (elw_u[u]) begin
                elcr_q[u] <= wdata & WMASK;
            end
        end

        pic_ctrl u_ctrl (
            .clk      (clk),
            .rst      (rst),
            .lvl_mode (elcr_q[u]),
            .pin_vld  (pinv_u[u]),
            .pin_idx  (line_num[PIN_W-1:0]),
            .pin_lvl  (line_lvl),
            .ext_set  (ext_u[u]),
            .cmd_wr   (cmdw_u[u]),
            .mask_wr  (maskw_u[u]),
            .wdata    (wdata),
            .rd_port  (dec.port),
            .ack      (ack_u[u]),
            .rdata    (rd_u[u]),
            .int_req  (req_u[u]),
            .int_line (line_u[u]),
            .base_o   (base_u[u]),
            .irr_o    (irr_u[u]),
            .isr_o    (isr_u[u])
        );
    end

    always_comb begin
        if (!(rd_en && dec.hit))   rdata = '0;
        else if (dec.el_sel)       rdata = elcr_q[dec.unit];
        else                       rdata = rd_u[dec.unit];
    end

    assign cpu_int = req_u[0];

    always_comb begin
        if (!req_u[0])             vec_n = {base_u[0], SPUR};
        else if (line_u[0] != CASC) vec_n = {base_u[0], line_u[0]};
        else if (req_u[1])         vec_n = {base_u[1], line_u[1]};
        else                       vec_n = {base_u[1], SPUR};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_vld <= 1'b0;
            vec     <= '0;
        end else begin
            vec_vld <= inta;
            if (inta) vec <= vec_n;
        end
    end

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        inta |=> vec_vld); // R8

    AST_NO_VEC_WITHOUT_ACK: assert property (@(posedge clk) disable iff (rst)
        !inta |=> !vec_vld); // R8

    AST_CASCADE_RAISES_PIN: assert property (@(posedge clk) disable iff (rst)
        (req_u[1] && !inta) |=> irr_u[0][CASC_PIN]); // R7

    AST_WIDE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_bytes != ACC_W'(1)) |=> ($stable(elcr_q[0]) && $stable(elcr_q[1]))); // R10

    AST_HIGH_LINE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (line_vld && line_num[LINE_W-1] && !inta) |=> $stable(irr_u[1])); // R2

endmodule

// File: tb/pic_cascade_top_tb_top.sv
module pic_cascade_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       line_vld;
    logic [4:0] line_num;
    logic       line_lvl;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [2:0] acc_bytes;
    logic [7:0] rdata;
    logic       cpu_int;
    logic       inta;
    logic       vec_vld;
    logic [7:0] vec;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    pic_cascade_top dut_i (
        .clk(clk), .rst(rst), .line_vld(line_vld), .line_num(line_num),
        .line_lvl(line_lvl), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .acc_bytes(acc_bytes), .rdata(rdata), .cpu_int(cpu_int),
        .inta(inta), .vec_vld(vec_vld), .vec(vec)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] nb = 3'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; acc_bytes = nb;
        @(negedge clk);
        wr_en = 1'b0; acc_bytes = 3'd1;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [2:0] nb, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; acc_bytes = nb;
        #1 d = rdata;
        rd_en = 1'b0; acc_bytes = 3'd1;
    endtask

    task automatic line_set(input logic [4:0] n, input logic l);
        @(negedge clk);
        line_vld = 1'b1; line_num = n; line_lvl = l;
        @(negedge clk);
        line_vld = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] n);
        line_set(n, 1'b1);
        line_set(n, 1'b0);
    endtask

    // driver: push the expected vector, then pulse the acknowledge
    task automatic do_ack(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    // monitor: pop and compare whenever a vector appears
    always @(negedge clk) begin
        if (vec_vld === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected vector", vec, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), vec, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; line_vld = 0; line_num = 0; line_lvl = 0;
        wr_en = 0; rd_en = 0; addr = 0; wdata = 0; acc_bytes = 3'd1; inta = 0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 cpu_int", {7'b0, cpu_int}, 8'h00);
        chk("R1 vec_vld", {7'b0, vec_vld}, 8'h00);
        bus_rd(8'h01, 3'd1, d); chk("R1 master mask", d, 8'h00);
        bus_rd(8'h10, 3'd1, d); chk("R1 master edge/level", d, 8'h00);

        // initialise bases
        bus_wr(8'h00, 8'h10); bus_wr(8'h01, 8'h20);
        bus_wr(8'h80, 8'h10); bus_wr(8'h81, 8'h28);

        // R2 R3 R8 master edge line
        line_set(5'd1, 1'b1);
        chk("R2 master line 1 raises cpu_int", {7'b0, cpu_int}, 8'h01);
        line_set(5'd1, 1'b0);
        chk("R3 edge request held after line falls", {7'b0, cpu_int}, 8'h01);
        do_ack(8'h21, "R8 master vector");
        chk("R3 edge request cleared by ack", {7'b0, cpu_int}, 8'h00);
        bus_wr(8'h00, 8'h20);

        // R7 cascade through slave line 12
        line_set(5'd12, 1'b1);
        idle(1);
        chk("R7 slave raises cpu_int", {7'b0, cpu_int}, 8'h01);
        bus_rd(8'h80, 3'd1, d); chk("R2 slave pin 4 latched", d, 8'h10);
        do_ack(8'h2C, "R8 slave vector");
        line_set(5'd12, 1'b0);
        bus_wr(8'h00, 8'h0B);
        bus_rd(8'h00, 3'd1, d); chk("R11 master in-service pin 2", d, 8'h04);
        bus_wr(8'h00, 8'h0A);
        bus_wr(8'h80, 8'h20); bus_wr(8'h00, 8'h20);
        chk("R7 cascade quiet after EOIs", {7'b0, cpu_int}, 8'h00);

        // R6 priority and in-service blocking
        line_set(5'd5, 1'b1); line_set(5'd3, 1'b1);
        do_ack(8'h23, "R6 line 3 first");
        chk("R6 line 5 blocked by service of 3", {7'b0, cpu_int}, 8'h00);
        bus_wr(8'h00, 8'h20);
        chk("R6 line 5 offered after EOI", {7'b0, cpu_int}, 8'h01);
        do_ack(8'h25, "R6 line 5 second");
        bus_wr(8'h00, 8'h20);
        line_set(5'd5, 1'b0); line_set(5'd3, 1'b0);

        // R9 spurious master
        do_ack(8'h27, "R9 master spurious");
        chk("R9 no interrupt after spurious", {7'b0, cpu_int}, 8'h00);

        // R9 spurious slave
        line_set(5'd9, 1'b1);
        idle(1);
        bus_wr(8'h81, 8'h02);
        chk("R7 master pin 2 stays latched", {7'b0, cpu_int}, 8'h01);
        bus_rd(8'h01, 3'd1, d); chk("R5 master mask untouched by slave write", d, 8'h00);
        do_ack(8'h2F, "R9 slave spurious");
        bus_wr(8'h00, 8'h20);
        bus_wr(8'h81, 8'h00);
        idle(1);
        do_ack(8'h29, "R12 slave pin 1 after unmask");
        bus_wr(8'h80, 8'h20); bus_wr(8'h00, 8'h20);
        line_set(5'd9, 1'b0);
        chk("R9 quiet after slave service", {7'b0, cpu_int}, 8'h00);

        // R4 edge/level write masks
        bus_wr(8'h10, 8'hFF);
        bus_rd(8'h10, 3'd1, d); chk("R4 master mask F8", d, 8'hF8);
        bus_wr(8'h11, 8'hFF);
        bus_rd(8'h11, 3'd1, d); chk("R4 slave mask DE", d, 8'hDE);

        // R3 level sensing on master line 3
        line_set(5'd3, 1'b1);
        do_ack(8'h23, "R3 level vector");
        bus_wr(8'h00, 8'h20);
        chk("R3 level request survives ack", {7'b0, cpu_int}, 8'h01);
        line_set(5'd3, 1'b0);
        chk("R3 level request follows line low", {7'b0, cpu_int}, 8'h00);
        bus_wr(8'h10, 8'h00); bus_wr(8'h11, 8'h00);

        // R2 out-of-range line
        line_set(5'd20, 1'b1);
        chk("R2 line 20 ignored cpu_int", {7'b0, cpu_int}, 8'h00);
        bus_rd(8'h00, 3'd1, d); chk("R2 master requests empty", d, 8'h00);
        bus_rd(8'h80, 3'd1, d); chk("R2 slave requests empty", d, 8'h00);
        line_set(5'd20, 1'b0);

        // R10 wide accesses / R5 unused address
        bus_wr(8'h01, 8'hFF, 3'd2);
        bus_rd(8'h01, 3'd1, d); chk("R10 wide write ignored", d, 8'h00);
        bus_wr(8'h10, 8'hFF);
        bus_rd(8'h10, 3'd4, d); chk("R10 wide read zero", d, 8'h00);
        bus_rd(8'h10, 3'd1, d); chk("R4 byte read after write", d, 8'hF8);
        bus_rd(8'h41, 3'd1, d); chk("R5 unused address reads zero", d, 8'h00);
        bus_wr(8'h10, 8'h00);

        // R12 masking
        bus_wr(8'h01, 8'h02);
        line_set(5'd1, 1'b1);
        chk("R12 masked pin not offered", {7'b0, cpu_int}, 8'h00);
        bus_rd(8'h00, 3'd1, d); chk("R12 masked request latched", d, 8'h02);
        bus_wr(8'h01, 8'h00);
        chk("R12 unmask offers request", {7'b0, cpu_int}, 8'h01);
        do_ack(8'h21, "R12 vector after unmask");
        bus_wr(8'h00, 8'h20);
        line_set(5'd1, 1'b0);

        // R11 set priority and specific EOI
        bus_wr(8'h00, 8'hC4);
        pulse(5'd3); pulse(5'd6);
        do_ack(8'h26, "R11 rotated priority picks 6");
        chk("R11 line 3 waits behind 6", {7'b0, cpu_int}, 8'h00);
        bus_wr(8'h00, 8'h66);
        chk("R11 specific EOI releases 3", {7'b0, cpu_int}, 8'h01);
        do_ack(8'h23, "R11 line 3 after specific EOI");
        bus_wr(8'h00, 8'h20);
        chk("R11 nonspecific EOI empties", {7'b0, cpu_int}, 8'h00);

        // R11 rotate on EOI
        bus_wr(8'h00, 8'hC7);
        pulse(5'd1); pulse(5'd5);
        do_ack(8'h21, "R11 line 1 before rotation");
        bus_wr(8'h00, 8'hA0);
        pulse(5'd0);
        do_ack(8'h25, "R11 rotation puts 5 before 0");
        bus_wr(8'h00, 8'h20);
        do_ack(8'h20, "R11 line 0 last");
        bus_wr(8'h00, 8'h20);

        idle(3);
        chk("R8 all vectors seen", 8'(exp_q.size()), 8'h00);
        done = 1;
        summary();
        $finish;
    end

endmodule